// File: doc/BRIEF.md
# Jittery Clock Trim Table Generator

This block builds a table of sixteen 8-bit oscillator trim codes. A clock that later steps through the table runs with a deliberate, spread-out frequency jitter. The block takes two calibration trims: one for a fast operating point and one for the nominal operating point. It also takes a mode select that widens the spread, a jitter enable, and a start strobe.

After an accepted start, the block walks a fixed-point setting with four fractional bits. The setting begins at the fast trim and grows by a step derived from the gap between the two trims. One table entry is written per clock. Codes saturate at the top of the 8-bit range. The walk jumps over a keep-out band centred on the nominal trim, so the jittery clock never sits close to the timer clock's frequency. With jitter disabled, every entry receives the nominal trim.

A lock input, once seen high, freezes the table and blocks every further start until reset. Entries are read back through a combinational index port.

Top module: `jitter_trim_gen`

## Requirements
- R1: Out of reset, all sixteen entries read 0, and `busy`, `done` and `locked` are low.
- R2: With jitter enabled and `wide_mode` low, the running setting S starts at fast·16. Entry i receives S>>4, and S then grows by 2·(nominal − fast). Results are defined for nominal ≥ fast.
- R3: With `wide_mode` high, the per-entry growth of S is (7·(nominal − fast))>>1 instead.
- R4: Whenever S exceeds 4095, the entry written is 255.
- R5: After each growth step, an S strictly above nominal·16 − 6·(nominal − fast) and strictly below nominal·16 + 6·(nominal − fast) is replaced by that upper bound.
- R6: With `jit_en` low, all sixteen entries receive the nominal trim.
- R7: `busy` rises on the edge that accepts `start`. Entries are written on the next 16 edges, in index order 0 to 15. On the 16th edge `busy` falls and `done` rises for exactly one cycle.
- R8: A `start` pulse while `busy` is high is ignored; the run in progress completes with its original configuration.
- R9: Once `lock` is sampled high, `locked` stays high until reset, any run in progress is abandoned, `start` is ignored, and the table no longer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| fast_trim | input | 8 | Calibration trim of the fast operating point |
| nom_trim | input | 8 | Calibration trim of the nominal operating point |
| wide_mode | input | 1 | Selects the wider step of 3.5·delta |
| jit_en | input | 1 | 1: build a spread; 0: fill with the nominal trim |
| start | input | 1 | Single-cycle request to build the table |
| lock | input | 1 | Freezes the table and configuration until reset |
| rd_idx | input | 4 | Table entry to read |
| rd_code | output | 8 | Trim code held at `rd_idx` (combinational) |
| busy | output | 1 | Table build in progress |
| done | output | 1 | One-cycle pulse after entry 15 is written |
| locked | output | 1 | Lock has been seen since reset |

## Verification
The result of a start is due at fixed offsets. `busy` must be high just after the accepting edge and for each of the following 15 edges. The full table and the `done` pulse are due just after the 16th edge, and `done` must be low again one edge later. The bench samples one time unit after each rising edge and counts edges from the start edge. Table contents are read back only after `done`, and are compared against an arithmetic model of the fixed-point walk for sweeps of trim pairs, both step modes and the disabled case. The lock and ignored-start checks read the table back through `rd_code` after a window longer than a full run.

// File: rtl/jitter_trim_gen.sv
module jitter_trim_gen #(
  parameter int NBANK = 16,
  parameter int TW = 8,
  parameter int FRAC = 4,
  parameter int AW = 16,
  parameter int SKIP_MUL = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TW-1:0]            fast_trim,
  input  logic [TW-1:0]            nom_trim,
  input  logic                     wide_mode,
  input  logic                     jit_en,
  input  logic                     start,
  input  logic                     lock,
  input  logic [$clog2(NBANK)-1:0] rd_idx,
  output logic [TW-1:0]            rd_code,
  output logic                     busy,
  output logic                     done,
  output logic                     locked
);
  localparam int IW = $clog2(NBANK);
  localparam logic [AW-1:0] SAT_LIM = AW'((1 << (TW + FRAC)) - 1);

  logic [TW-1:0] bank_q [NBANK];
  logic [TW-1:0] nom_q;
  logic          en_q, busy_q, done_q, locked_q;
  logic [AW-1:0] set_q, step_q, lo_q, hi_q;
  logic [IW-1:0] idx_q;

  logic [AW-1:0] delta_w, base_w, step_w, add_w, nxt_w;
  logic [TW-1:0] code_w;
  logic          lock_eff, last_w;

  assign delta_w  = AW'(nom_trim) - AW'(fast_trim);
  assign base_w   = AW'(nom_trim) << FRAC;
  assign step_w   = wide_mode ? ((delta_w * AW'(7)) >> 1) : (delta_w << 1);
  assign add_w    = set_q + step_q;
  assign nxt_w    = (add_w > lo_q && add_w < hi_q) ? hi_q : add_w;
  assign code_w   = !en_q ? nom_q :
                    (set_q > SAT_LIM) ? '1 : set_q[TW+FRAC-1:FRAC];
  assign lock_eff = lock | locked_q;
  assign last_w   = idx_q == IW'(NBANK - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBANK; i++) bank_q[i] <= '0;
      nom_q    <= '0;
      en_q     <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      locked_q <= 1'b0;
      set_q    <= '0;
      step_q   <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      idx_q    <= '0;
    end else begin
      locked_q <= locked_q | lock;
      done_q   <= 1'b0;
      if (lock_eff) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        bank_q[idx_q] <= code_w;
        set_q <= nxt_w;
        idx_q <= idx_q + 1'b1;
        if (last_w) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start) begin
        nom_q  <= nom_trim;
        en_q   <= jit_en;
        step_q <= step_w;
        lo_q   <= base_w - delta_w * AW'(SKIP_MUL);
        hi_q   <= base_w + delta_w * AW'(SKIP_MUL);
        set_q  <= AW'(fast_trim) << FRAC;
        idx_q  <= '0;
        busy_q <= 1'b1;
      end
    end
  end

  assign rd_code = bank_q[rd_idx];
  assign busy    = busy_q;
  assign done    = done_q;
  assign locked  = locked_q;
endmodule

// File: rtl/jitter_trim_gen_chk.sv
module jitter_trim_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic locked
);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  a_r7_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r9_locked_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  a_r9_locked_idle: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (!busy && !done));
endmodule

bind jitter_trim_gen jitter_trim_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .locked(locked)
);

// File: tb/jitter_trim_gen_bench.sv
module jitter_trim_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] fast_trim = '0, nom_trim = '0;
  logic       wide_mode = 1'b0, jit_en = 1'b0, start = 1'b0, lock = 1'b0;
  logic [3:0] rd_idx = '0;
  logic [7:0] rd_code;
  logic       busy, done, locked;

  int errors = 0, checks = 0;
  int exp_code [16];
  string exp_tag [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  jitter_trim_gen u_jitter_trim_gen (
    .clk(clk), .rst_n(rst_n), .fast_trim(fast_trim), .nom_trim(nom_trim),
    .wide_mode(wide_mode), .jit_en(jit_en), .start(start), .lock(lock),
    .rd_idx(rd_idx), .rd_code(rd_code), .busy(busy), .done(done), .locked(locked)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model(input int f, input int n, input int h, input int e);
    int s, d, st, lo, hi;
    bit sk;
    s = f * 16; d = n - f;
    st = h ? (d * 7) >> 1 : 2 * d;
    lo = n * 16 - 6 * d; hi = n * 16 + 6 * d;
    sk = 0;
    for (int i = 0; i < 16; i++) begin
      if (!e) begin
        exp_code[i] = n; exp_tag[i] = "R6";
      end else begin
        exp_code[i] = (s > 4095) ? 255 : (s >> 4);
        exp_tag[i] = (s > 4095) ? "R4" : sk ? "R5" : h ? "R3" : "R2";
        s = s + st;
        sk = (s > lo && s < hi);
        if (sk) s = hi;
      end
    end
  endtask

  task automatic check_table(input string what);
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i);
      #1;
      check(exp_tag[i], rd_code, exp_code[i], $sformatf("%s entry %0d", what, i));
    end
  endtask

  task automatic run(input int f, input int n, input int h, input int e, input bit restart);
    @(negedge clk);
    fast_trim = 8'(f); nom_trim = 8'(n); wide_mode = h[0]; jit_en = e[0]; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check("R7", busy, 1, "busy after start edge");
    for (int c = 1; c <= 16; c++) begin
      if (restart && c == 5) begin
        fast_trim = 8'd3; nom_trim = 8'd200; jit_en = 1'b1; wide_mode = ~wide_mode; start = 1'b1;
      end
      @(posedge clk); #1;
      start = 1'b0;
      if (c < 16) begin
        if (busy !== 1'b1 || done !== 1'b0)
          check("R7", {busy, done}, 2, $sformatf("busy/done at edge %0d", c));
      end else begin
        check("R7", {busy, done}, 1, "busy/done at edge 16");
      end
    end
    @(posedge clk); #1;
    check("R7", done, 0, "done single cycle");
    model(f, n, h, e);
    check_table(restart ? "R8 restart ignored" : "table");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", {busy, done, locked}, 0, "flags after reset");
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i); #1;
      check("R1", rd_code, 0, $sformatf("entry %0d after reset", i));
    end
    @(negedge clk); rst_n = 1'b1;

    run(8'h40, 8'h80, 0, 1, 0);   // R5 skip case
    run(8'hF0, 8'hFF, 0, 1, 0);   // R4 saturation
    run(8'h20, 8'hF0, 1, 1, 0);   // R3 and R4
    run(8'h50, 8'h90, 0, 0, 0);   // R6
    for (int f = 0; f < 256; f += 37)
      for (int n = f; n < 256; n += 41)
        for (int m = 0; m < 3; m++)
          run(f, n, (m == 1) ? 1 : 0, (m == 2) ? 0 : 1, 0);
    run(8'h30, 8'hA0, 0, 1, 1);   // R8 start while busy

    // R9 lock freezes the table
    model(8'h30, 8'hA0, 0, 1);
    @(negedge clk); lock = 1'b1;
    @(negedge clk); lock = 1'b0;
    check("R9", locked, 1, "locked after lock");
    fast_trim = 8'h01; nom_trim = 8'h02; jit_en = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R9", busy, 0, "start ignored when locked");
    repeat (20) @(negedge clk);
    check("R9", {busy, locked}, 1, "still locked, idle");
    check_table("R9 frozen");

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    check("R1", {busy, done, locked}, 0, "flags after second reset");
    rd_idx = 4'd7; #1;
    check("R1", rd_code, 0, "entry 7 after second reset");
    run(8'h10, 8'h60, 1, 1, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule